// File: doc/BRIEF.md
# Flash Command and Interrupt Register Core

This block is the register front end of a flash device controller. A host writes opcodes, configuration words and interrupt acknowledgements through a simple single-port register interface, and reads back the command, configuration, controller status and interrupt status words. Each opcode that is accepted and belongs to an operation engine goes out as a one-cycle start strobe with the opcode alongside. The engines report back through a one-cycle done pulse that carries a kind code and an error flag.

The core merges completions and errors into its interrupt status and controller status words. It raises a global interrupt flag that blocks any further command until the host acknowledges it. It drives an interrupt pin whose active level is chosen by a configuration bit, and a ready pin that follows a configuration bit. Two opcodes perform a warm reset of the register state. Unknown opcodes are flagged as command errors.

Register map (address to word): 0 command, 1 configuration A, 2 configuration B, 3 controller status (read-only), 4 interrupt status. Addresses 5 to 7 are unmapped.

Top module: `fr_regcore`

## Requirements
- R1: After a synchronous cold reset (rst_n low at a clock edge), configuration A reads 0x40C0, configuration B reads 0, controller status reads 0, interrupt status reads 0x8080, the command word reads 0, rdy_out is 1 and irq_out is 1.
- R2: While interrupt status bit 15 is set, a write to the command address has no effect: the command word is unchanged, no cmd_start occurs, and a reset opcode does not reset anything.
- R3: An accepted write of an engine opcode (0x00, 0x13, 0x80, 0x1A, 0x1B, 0x94, 0x95, 0x30, 0xB0, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x65) stores it in the command word and drives cmd_start high for exactly the one cycle after the write edge, with cmd_op equal to the opcode.
- R4: An accepted write of any other opcode except the reset opcodes sets controller status bit 10 and interrupt status bit 15 and produces no cmd_start.
- R5: An accepted write of opcode 0xF0 or 0xF3 performs a warm reset: interrupt status becomes 0x8010, configuration A 0x40C0, configuration B 0, controller status 0, command word 0, rdy_out 1, and no cmd_start occurs.
- R6: A write to the interrupt status address ANDs the written value into interrupt status; if bit 15 of the result is clear, controller status bits 10 to 13 are cleared, otherwise they are kept.
- R7: A done pulse sets interrupt status bit 15 and, by kind code, bit 5 (kind 1, erase), bit 6 (kind 2, program), bit 7 (kind 3, load) or no further bit (kind 0); with its error flag it also sets status bit 10 plus bit 11, 12 or 13 for kinds 1, 2, 3.
- R8: When a done pulse and an interrupt acknowledge write fall in the same cycle, the acknowledge is applied first and the bits set by the done pulse are kept.
- R9: irq_out equals interrupt status bit 15 XOR the inverse of configuration A bit 6, registered, so it follows a change one clock later.
- R10: Configuration A reads back masked with 0xFFE0, and a write to it sets rdy_out to the written bit 7.
- R11: Configuration B is a full 16-bit read and write word.
- R12: Unmapped addresses read 0, and writes to controller status are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| cmd_start | output | 1 | One-cycle start strobe to the engines |
| cmd_op | output | 16 | Opcode presented with cmd_start |
| done_valid | input | 1 | Engine completion pulse |
| done_kind | input | 2 | Completion kind: 0 none, 1 erase, 2 program, 3 load |
| done_err | input | 1 | Completion carried an error |
| irq_out | output | 1 | Interrupt pin, level chosen by configuration A bit 6 |
| rdy_out | output | 1 | Ready pin |

## Verification
The collision that matters is an engine done pulse landing in the same cycle as the host's interrupt acknowledge write. The bench leaves an old load error pending, then drives an erase-with-error completion on the very edge where the host writes zero to interrupt status. The result is judged by reading back that the old load error bit is gone while the new erase flag and erase error remain. The command gate is also probed against a pending flag, by writing a reset opcode that must not take effect.

// File: rtl/fr_pkg.sv
// Shared constants and types for the flash register core.
// Assumes a 16-bit register word and a 3-bit register address.
package fr_pkg;
    localparam int DW = 16;
    localparam int AW = 3;

    // Register addresses
    localparam logic [AW-1:0] A_CMD  = 3'd0;
    localparam logic [AW-1:0] A_CFGA = 3'd1;
    localparam logic [AW-1:0] A_CFGB = 3'd2;
    localparam logic [AW-1:0] A_STAT = 3'd3;
    localparam logic [AW-1:0] A_INT  = 3'd4;

    // Done kind codes
    localparam logic [1:0] DK_NONE  = 2'd0;
    localparam logic [1:0] DK_ERASE = 2'd1;
    localparam logic [1:0] DK_PROG  = 2'd2;
    localparam logic [1:0] DK_LOAD  = 2'd3;

    // Bit positions
    localparam int IB_GLOBAL = 15;
    localparam int IB_ERASE  = 5;
    localparam int IB_PROG   = 6;
    localparam int IB_LOAD   = 7;
    localparam int SB_CMD    = 10;
    localparam int SB_ERASE  = 11;
    localparam int SB_PROG   = 12;
    localparam int SB_LOAD   = 13;
    localparam int CB_IRQPOL = 6;
    localparam int CB_RDY    = 7;

    localparam logic [DW-1:0] ERR_MASK     = 16'h3C00;
    localparam logic [DW-1:0] CFGA_RDMASK  = 16'hFFE0;
    localparam logic [DW-1:0] CFGA_RST     = 16'h40C0;
    localparam logic [DW-1:0] INT_COLD     = 16'h8080;
    localparam logic [DW-1:0] INT_WARM     = 16'h8010;

    typedef enum logic [1:0] {
        OPC_ENGINE = 2'd0,
        OPC_RESET  = 2'd1,
        OPC_BAD    = 2'd2
    } op_class_e;
endpackage

// File: rtl/fr_op_decode.sv
// Classifies a written opcode as an engine command, a warm reset or unknown.
// Assumes the full write word is the opcode; any upper bit set means unknown.
module fr_op_decode
    import fr_pkg::*;
(
    input  logic [DW-1:0] op,
    output op_class_e     cls
);
    // Purpose: map each opcode to its class
    always_comb begin
        case (op)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0094, 16'h0095, 16'h0030, 16'h00B0,
            16'h0023, 16'h0027, 16'h002A, 16'h002C,
            16'h0071, 16'h0065:      cls = OPC_ENGINE;
            16'h00F0, 16'h00F3:      cls = OPC_RESET;
            default:                 cls = OPC_BAD;
        endcase
    end
endmodule

// File: rtl/fr_event_status.sv
// Holds the interrupt status and controller status words.
// Applies, in order: host acknowledge (AND), error clear, then the flags
// from a rejected opcode and from an engine done pulse. Warm reset wins.
module fr_event_status
    import fr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          ack_we,
    input  logic [DW-1:0] ack_val,
    input  logic          bad_cmd,
    input  logic          done_valid,
    input  logic [1:0]    done_kind,
    input  logic          done_err,
    output logic [DW-1:0] intst,
    output logic [DW-1:0] status
);
    logic [DW-1:0] int_nx, st_nx;

    // Purpose: merge acknowledge, command error and completion into next state
    always_comb begin
        int_nx = ack_we ? (intst & ack_val) : intst;
        st_nx  = status;
        if (ack_we && !int_nx[IB_GLOBAL])
            st_nx = st_nx & ~ERR_MASK;
        if (bad_cmd) begin
            int_nx[IB_GLOBAL] = 1'b1;
            st_nx[SB_CMD]     = 1'b1;
        end
        if (done_valid) begin
            int_nx[IB_GLOBAL] = 1'b1;
            case (done_kind)
                DK_ERASE: int_nx[IB_ERASE] = 1'b1;
                DK_PROG:  int_nx[IB_PROG]  = 1'b1;
                DK_LOAD:  int_nx[IB_LOAD]  = 1'b1;
                default:  ;
            endcase
            if (done_err) begin
                st_nx[SB_CMD] = 1'b1;
                case (done_kind)
                    DK_ERASE: st_nx[SB_ERASE] = 1'b1;
                    DK_PROG:  st_nx[SB_PROG]  = 1'b1;
                    DK_LOAD:  st_nx[SB_LOAD]  = 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // Purpose: register both words with cold and warm reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intst  <= INT_COLD;
            status <= '0;
        end else if (warm_rst) begin
            intst  <= INT_WARM;
            status <= '0;
        end else begin
            intst  <= int_nx;
            status <= st_nx;
        end
    end
endmodule

// File: rtl/fr_config.sv
// Holds the two configuration words and the ready pin.
// Assumes ready follows configuration A bit 7 only on a write to that word.
module fr_config
    import fr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          cfga_we,
    input  logic          cfgb_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfga,
    output logic [DW-1:0] cfgb,
    output logic          rdy
);
    // Purpose: update configuration words and ready pin
    always_ff @(posedge clk) begin
        if (!rst_n || warm_rst) begin
            cfga <= CFGA_RST;
            cfgb <= '0;
            rdy  <= 1'b1;
        end else begin
            if (cfga_we) begin
                cfga <= wdata;
                rdy  <= wdata[CB_RDY];
            end
            if (cfgb_we)
                cfgb <= wdata;
        end
    end
endmodule

// File: rtl/fr_regcore.sv
// Top of the flash command and interrupt register core.
// Decodes host writes, gates commands on the pending interrupt flag,
// strobes engine opcodes out and drives the registered interrupt pin.
// Assumes one register access per cycle and a combinational read port.
module fr_regcore
    import fr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          cmd_start,
    output logic [DW-1:0] cmd_op,
    input  logic          done_valid,
    input  logic [1:0]    done_kind,
    input  logic          done_err,
    output logic          irq_out,
    output logic          rdy_out
);
    logic [DW-1:0] cmd_q;
    logic [DW-1:0] intst, status, cfga, cfgb;
    logic          cmd_acc, warm_rst, bad_cmd, start_q, irq_q;
    op_class_e     op_cls;

    fr_op_decode u_dec (.op(wdata), .cls(op_cls));

    // Purpose: command accepted only when no interrupt is pending
    always_comb begin
        cmd_acc  = wr_en && (addr == A_CMD) && !intst[IB_GLOBAL];
        warm_rst = cmd_acc && (op_cls == OPC_RESET);
        bad_cmd  = cmd_acc && (op_cls == OPC_BAD);
    end

    fr_event_status u_evt (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .ack_we(wr_en && addr == A_INT), .ack_val(wdata),
        .bad_cmd(bad_cmd), .done_valid(done_valid),
        .done_kind(done_kind), .done_err(done_err),
        .intst(intst), .status(status)
    );

    fr_config u_cfg (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .cfga_we(wr_en && addr == A_CFGA), .cfgb_we(wr_en && addr == A_CFGB),
        .wdata(wdata), .cfga(cfga), .cfgb(cfgb), .rdy(rdy_out)
    );

    // Purpose: command word, start strobe and registered interrupt pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            start_q <= 1'b0;
            irq_q   <= INT_COLD[IB_GLOBAL] ^ ~CFGA_RST[CB_IRQPOL];
        end else begin
            start_q <= cmd_acc && (op_cls == OPC_ENGINE);
            irq_q   <= intst[IB_GLOBAL] ^ ~cfga[CB_IRQPOL];
            if (warm_rst)
                cmd_q <= '0;
            else if (cmd_acc)
                cmd_q <= wdata;
        end
    end

    // Purpose: read multiplexer
    always_comb begin
        case (addr)
            A_CMD:   rdata = cmd_q;
            A_CFGA:  rdata = cfga & CFGA_RDMASK;
            A_CFGB:  rdata = cfgb;
            A_STAT:  rdata = status;
            A_INT:   rdata = intst;
            default: rdata = '0;
        endcase
    end

    assign cmd_start = start_q;
    assign cmd_op    = cmd_q;
    assign irq_out   = irq_q;
endmodule

// File: rtl/fr_regcore_chk.sv
// Assertion checker for fr_regcore, attached by bind.
// Assumes the bench holds rst_n low for at least one edge at start.
module fr_regcore_chk
    import fr_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic          done_valid,
    input logic          cmd_start,
    input logic          irq_out,
    input logic [DW-1:0] intst,
    input logic [DW-1:0] status,
    input logic [DW-1:0] cfga,
    input op_class_e     op_cls
);
    assert_cmd_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMD && intst[IB_GLOBAL]) |=> !cmd_start);

    assert_start_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMD && !intst[IB_GLOBAL] && op_cls == OPC_ENGINE)
        |=> cmd_start);

    assert_bad_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMD && !intst[IB_GLOBAL] && op_cls == OPC_BAD)
        |=> (status[SB_CMD] && intst[IB_GLOBAL] && !cmd_start));

    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_INT && !wdata[IB_GLOBAL] && !done_valid)
        |=> ((status & ERR_MASK) == '0));

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> intst[IB_GLOBAL]);

    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_out == ($past(intst[IB_GLOBAL]) ^ !$past(cfga[CB_IRQPOL]))));
endmodule

bind fr_regcore fr_regcore_chk u_chk (.*);

// File: tb/sim_fr_regcore.sv
module sim_fr_regcore;
    import fr_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          cmd_start;
    logic [DW-1:0] cmd_op;
    logic          done_valid = 1'b0;
    logic [1:0]    done_kind = '0;
    logic          done_err = 1'b0;
    logic          irq_out, rdy_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    fr_regcore u0 (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Drive at negedge, commit at posedge, return at following negedge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic done(input logic [1:0] k, input logic e);
        @(negedge clk);
        done_valid = 1'b1; done_kind = k; done_err = e;
        @(negedge clk);
        done_valid = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        rd(A_CFGA, v); check("R1 cfgA", v, 16'h40C0);
        rd(A_CFGB, v); check("R1 cfgB", v, 16'h0000);
        rd(A_STAT, v); check("R1 status", v, 16'h0000);
        rd(A_INT, v);  check("R1 intst", v, 16'h8080);
        rd(A_CMD, v);  check("R1 cmd", v, 16'h0000);
        check("R1 rdy", {15'd0, rdy_out}, 16'd1);
        check("R1 irq", {15'd0, irq_out}, 16'd1);
    endtask

    task automatic t_drop();
        logic [DW-1:0] v;
        wr(A_CMD, 16'h0094);
        check("R2 no start", {15'd0, cmd_start}, 16'd0);
        rd(A_CMD, v); check("R2 cmd kept", v, 16'h0000);
        wr(A_CMD, 16'h00F3);
        rd(A_INT, v); check("R2 reset opcode dropped", v, 16'h8080);
    endtask

    task automatic t_ack_irq();
        logic [DW-1:0] v;
        wr(A_INT, 16'h0000);
        rd(A_INT, v); check("R6 ack clears", v, 16'h0000);
        check("R9 irq not yet", {15'd0, irq_out}, 16'd1);
        @(negedge clk);
        check("R9 irq low", {15'd0, irq_out}, 16'd0);
    endtask

    task automatic t_start();
        logic [DW-1:0] v;
        wr(A_CMD, 16'h0080);
        check("R3 start high", {15'd0, cmd_start}, 16'd1);
        check("R3 cmd_op", cmd_op, 16'h0080);
        rd(A_CMD, v); check("R3 cmd word", v, 16'h0080);
        @(negedge clk);
        check("R3 start one cycle", {15'd0, cmd_start}, 16'd0);
    endtask

    task automatic t_done();
        logic [DW-1:0] v;
        done(DK_PROG, 1'b0);
        rd(A_INT, v);  check("R7 program done", v, 16'h8040);
        rd(A_STAT, v); check("R7 no error", v, 16'h0000);
        check("R9 irq lag", {15'd0, irq_out}, 16'd0);
        @(negedge clk);
        check("R9 irq raised", {15'd0, irq_out}, 16'd1);
        wr(A_INT, 16'h0000);
        done(DK_NONE, 1'b1);
        rd(A_INT, v);  check("R7 kind none", v, 16'h8000);
        rd(A_STAT, v); check("R7 kind none err", v, 16'h0400);
        wr(A_INT, 16'h0000);
    endtask

    task automatic t_ack_rules();
        logic [DW-1:0] v;
        done(DK_LOAD, 1'b1);
        rd(A_INT, v);  check("R7 load done", v, 16'h8080);
        rd(A_STAT, v); check("R7 load error", v, 16'h2400);
        wr(A_INT, 16'hFF7F);
        rd(A_INT, v);  check("R6 partial ack", v, 16'h8000);
        rd(A_STAT, v); check("R6 errors kept", v, 16'h2400);
        wr(A_INT, 16'h0000);
        rd(A_STAT, v); check("R6 errors cleared", v, 16'h0000);
    endtask

    task automatic t_bad();
        logic [DW-1:0] v;
        wr(A_CMD, 16'h0042);
        check("R4 no start", {15'd0, cmd_start}, 16'd0);
        rd(A_STAT, v); check("R4 cmd error", v, 16'h0400);
        rd(A_INT, v);  check("R4 flag", v, 16'h8000);
        wr(A_INT, 16'h0000);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        done(DK_LOAD, 1'b1);
        @(negedge clk);
        wr_en = 1'b1; addr = A_INT; wdata = 16'h0000;
        done_valid = 1'b1; done_kind = DK_ERASE; done_err = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; done_valid = 1'b0;
        rd(A_INT, v);  check("R8 done survives ack", v, 16'h8020);
        rd(A_STAT, v); check("R8 old error cleared", v, 16'h0C00);
    endtask

    task automatic t_cfg();
        logic [DW-1:0] v;
        wr(A_CFGA, 16'h0F3F);
        rd(A_CFGA, v); check("R10 masked read", v, 16'h0F20);
        check("R10 rdy low", {15'd0, rdy_out}, 16'd0);
        @(negedge clk);
        check("R9 polarity flip", {15'd0, irq_out}, 16'd0);
        wr(A_CFGA, 16'h00C5);
        rd(A_CFGA, v); check("R10 masked read 2", v, 16'h00C0);
        check("R10 rdy high", {15'd0, rdy_out}, 16'd1);
        wr(A_CFGB, 16'hA5C3);
        rd(A_CFGB, v); check("R11 cfgB", v, 16'hA5C3);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] v;
        for (int a = 5; a < 8; a++) begin
            rd(AW'(a), v); check("R12 unmapped", v, 16'h0000);
        end
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, v); check("R12 status write ignored", v, 16'h0C00);
    endtask

    task automatic t_warm(input logic [DW-1:0] op);
        logic [DW-1:0] v;
        wr(A_INT, 16'h0000);
        wr(A_CFGA, 16'h1234);
        wr(A_CFGB, 16'h5678);
        wr(A_CMD, 16'h0013);
        wr(A_CMD, op);
        check("R5 no start", {15'd0, cmd_start}, 16'd0);
        rd(A_INT, v);  check("R5 intst", v, 16'h8010);
        rd(A_CFGA, v); check("R5 cfgA", v, 16'h40C0);
        rd(A_CFGB, v); check("R5 cfgB", v, 16'h0000);
        rd(A_STAT, v); check("R5 status", v, 16'h0000);
        rd(A_CMD, v);  check("R5 cmd", v, 16'h0000);
        check("R5 rdy", {15'd0, rdy_out}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_drop();
        t_ack_irq();
        t_start();
        t_done();
        t_ack_rules();
        t_bad();
        t_collide();
        t_cfg();
        t_unmapped();
        t_warm(16'h00F3);
        t_warm(16'h00F0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule